// File: doc/BRIEF.md
# Dual-Form Maximal-Length Pseudo-Random Sequence Generator

This block is a parameterised linear-feedback shift register for pseudo-random test patterns, noise sources or cheap event counting. Its width can be set anywhere from 2 to 64 bits. A parameter picks one of two structures. The first is a shift chain with an XNOR feedback bit that re-enters at the low end. The second is a chain in which the top bit wraps to the bottom and is XORed into the tapped stages on the way. A tap-mask parameter sets the feedback polynomial. Its default gives the maximal-length 16-bit sequence, with taps at positions 16, 15, 13 and 4 counted from one.

Each structure has one state in which it would stay forever. For the XNOR chain this is all ones; for the XOR chain it is all zeros. Reset always loads a seed that is safe for the chosen form. A seed load that would land on the lockup value is replaced by that safe seed. A combinational flag reports whenever the register holds the lockup value.

Top module: `prng_shiftreg`

## Requirements
- R1: In the XNOR form, one enabled step shifts the state one place toward the MSB. The new bit 0 is the inverse of the XOR of every state bit k-1 whose tap position k is set in the mask, where mask bit k-1 stands for tap position k. The default mask is 16'hD008.
- R2: In the XOR form, one enabled step moves the old MSB into bit 0. Each bit i from 1 to WIDTH-1 takes old bit i-1, XORed with the old MSB when mask bit i-1 is set.
- R3: Reset is synchronous. On the edge after reset is sampled high, the state is all zeros in the XNOR form and the value 1 in the XOR form, and the lockup flag is low.
- R4: With reset, load and enable all low, the state holds. With enable high, each edge produces a state different from the one before.
- R5: A sampled load replaces the state with the load value on the next edge and overrides the enable. A sampled reset overrides the load.
- R6: When the load value equals the lockup state of the selected form (all ones for XNOR, all zeros for XOR), the reset seed of that form is loaded instead.
- R7: The lockup flag is high exactly while the state equals the lockup value of the selected form. Starting from reset, it never rises under any mix of enable and load.
- R8: With the default 16-bit mask, both forms run from their reset seed through 65,535 enabled steps. No state repeats before the register returns to its starting value on step 65,535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset to the safe seed of the form |
| en | input | 1 | Advance the sequence by one step |
| load | input | 1 | Replace the state with load_val |
| load_val | input | WIDTH | Seed value for a load |
| state | output | WIDTH | Current register contents |
| lockup | output | 1 | State equals the lockup value of the form |

## Verification
The bench runs both forms side by side against models written from the step rules. It aims first at seed loads of the exact lockup value. A design that skipped the substitution would freeze for good and raise its flag. Loads of the other form's lockup value must pass unchanged, so a guard that picked the wrong pattern would show up as a wrong state. Cases where reset, load and enable are high together catch a swapped priority, which would let the sequence step or take the load value instead of the seed. The full-period run catches a misplaced tap or a wrong shift direction, because either one shortens the cycle or repeats a state early.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

   typedef enum logic {
      FORM_FIB = 1'b0,
      FORM_GAL = 1'b1
   } lfsr_form_e;

   // value the selected form can never leave
   function automatic logic [63:0] lock_pattern(lfsr_form_e form, int width);
      logic [63:0] ones;
      ones = (64'd1 << width) - 64'd1;
      return (form == FORM_FIB) ? ones : 64'd0;
   endfunction

   // safe starting value for the selected form
   function automatic logic [63:0] seed_pattern(lfsr_form_e form);
      return (form == FORM_FIB) ? 64'd0 : 64'd1;
   endfunction

endpackage

// File: rtl/lfsr_next.sv
module lfsr_next #(
   parameter int                  W    = 16,
   parameter lfsr_pkg::lfsr_form_e FORM = lfsr_pkg::FORM_FIB,
   parameter logic [63:0]         MASK = 64'hD008
) (
   input  logic [W-1:0] cur,
   output logic [W-1:0] nxt
);
   localparam logic [W-1:0] TAPS = MASK[W-1:0];

   generate
      if (FORM == lfsr_pkg::FORM_FIB) begin : g_fib
         logic fb;
         assign fb  = ~(^(cur & TAPS));
         assign nxt = {cur[W-2:0], fb};
      end else begin : g_gal
         logic top;
         assign top    = cur[W-1];
         assign nxt[0] = top;
         for (genvar i = 1; i < W; i++) begin : g_stage
            assign nxt[i] = cur[i-1] ^ (TAPS[i-1] & top);
         end
      end
   endgenerate
endmodule

// File: rtl/lfsr_seed_guard.sv
module lfsr_seed_guard #(
   parameter int                  W    = 16,
   parameter lfsr_pkg::lfsr_form_e FORM = lfsr_pkg::FORM_FIB
) (
   input  logic [W-1:0] raw_val,
   output logic [W-1:0] safe_val
);
   localparam logic [W-1:0] LOCK = W'(lfsr_pkg::lock_pattern(FORM, W));
   localparam logic [W-1:0] SEED = W'(lfsr_pkg::seed_pattern(FORM));

   always_comb begin
      safe_val = raw_val;
      if (raw_val == LOCK) safe_val = SEED;
   end
endmodule

// File: rtl/lfsr_lock_detect.sv
module lfsr_lock_detect #(
   parameter int                  W    = 16,
   parameter lfsr_pkg::lfsr_form_e FORM = lfsr_pkg::FORM_FIB
) (
   input  logic [W-1:0] cur,
   output logic         stuck
);
   localparam logic [W-1:0] LOCK = W'(lfsr_pkg::lock_pattern(FORM, W));

   assign stuck = (cur == LOCK);
endmodule

// File: rtl/prng_shiftreg.sv
module prng_shiftreg #(
   parameter int                  WIDTH    = 16,
   parameter lfsr_pkg::lfsr_form_e FORM     = lfsr_pkg::FORM_FIB,
   parameter logic [63:0]         TAP_MASK = 64'hD008
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   output logic [WIDTH-1:0] state,
   output logic             lockup
);
   localparam logic [WIDTH-1:0] SEED = WIDTH'(lfsr_pkg::seed_pattern(FORM));

   // elaboration-time parameter checks
   generate
      if (WIDTH < 2 || WIDTH > 64) begin : g_bad_width
         $error("prng_shiftreg: WIDTH must lie in 2..64");
      end else begin : g_width_ok
         if (TAP_MASK[WIDTH-1] != 1'b1) begin : g_no_top_tap
            $error("prng_shiftreg: top tap must be set");
         end
         if ((TAP_MASK >> WIDTH) != 64'd0) begin : g_stray_tap
            $error("prng_shiftreg: tap mask has bits above WIDTH");
         end
      end
   endgenerate

   logic [WIDTH-1:0] step_val;
   logic [WIDTH-1:0] seed_val;

   lfsr_next #(.W(WIDTH), .FORM(FORM), .MASK(TAP_MASK)) i_next (
      .cur (state),
      .nxt (step_val)
   );

   lfsr_seed_guard #(.W(WIDTH), .FORM(FORM)) i_guard (
      .raw_val  (load_val),
      .safe_val (seed_val)
   );

   lfsr_lock_detect #(.W(WIDTH), .FORM(FORM)) i_lock (
      .cur   (state),
      .stuck (lockup)
   );

   always_ff @(posedge clk) begin
      if (rst)       state <= SEED;
      else if (load) state <= seed_val;
      else if (en)   state <= step_val;
   end
endmodule

// File: rtl/lfsr_chk.sv
module lfsr_chk #(
   parameter int                  W    = 16,
   parameter lfsr_pkg::lfsr_form_e FORM = lfsr_pkg::FORM_FIB
) (
   input logic         clk,
   input logic         rst,
   input logic         en,
   input logic         load,
   input logic [W-1:0] load_val,
   input logic [W-1:0] state,
   input logic         lockup
);
   localparam logic [W-1:0] LOCK = W'(lfsr_pkg::lock_pattern(FORM, W));
   localparam logic [W-1:0] SEED = W'(lfsr_pkg::seed_pattern(FORM));

   a_r3_reset_seed: assert property (@(posedge clk)
      rst |=> (state == SEED) && !lockup);

   a_r4_hold: assert property (@(posedge clk) disable iff (rst)
      (!load && !en) |=> $stable(state));

   a_r4_advance: assert property (@(posedge clk) disable iff (rst)
      (!load && en) |=> state != $past(state));

   a_r5_load: assert property (@(posedge clk) disable iff (rst)
      load |=> state == (($past(load_val) == LOCK) ? SEED : $past(load_val)));

   a_r6_load_safe: assert property (@(posedge clk) disable iff (rst)
      load |=> !lockup);

   a_r7_never_stuck: assert property (@(posedge clk) disable iff (rst)
      !lockup);
endmodule

bind prng_shiftreg lfsr_chk #(.W(WIDTH), .FORM(FORM)) i_chk (
   .clk      (clk),
   .rst      (rst),
   .en       (en),
   .load     (load),
   .load_val (load_val),
   .state    (state),
   .lockup   (lockup)
);

// File: tb/test_prng_shiftreg.sv
`timescale 1ns/1ps
module test_prng_shiftreg;
   localparam int          W    = 16;
   localparam logic [15:0] MASK = 16'hD008;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en = 1'b0;
   logic load = 1'b0;
   logic [W-1:0] load_val = '0;
   logic [W-1:0] st_f, st_g;
   logic lk_f, lk_g;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [W-1:0] mf, mg;

   always #10 clk = ~clk;

   prng_shiftreg #(.WIDTH(W), .FORM(lfsr_pkg::FORM_FIB), .TAP_MASK(64'hD008)) i_prng_shiftreg (
      .clk(clk), .rst(rst), .en(en), .load(load), .load_val(load_val),
      .state(st_f), .lockup(lk_f));

   prng_shiftreg #(.WIDTH(W), .FORM(lfsr_pkg::FORM_GAL), .TAP_MASK(64'hD008)) i_prng_shiftreg_gal (
      .clk(clk), .rst(rst), .en(en), .load(load), .load_val(load_val),
      .state(st_g), .lockup(lk_g));

   function automatic logic [W-1:0] fib_step(logic [W-1:0] s);
      logic fb = 1'b0;
      for (int k = 0; k < W; k++) if (MASK[k]) fb = fb ^ s[k];
      return {s[W-2:0], ~fb};
   endfunction

   function automatic logic [W-1:0] gal_step(logic [W-1:0] s);
      logic [W-1:0] n;
      n[0] = s[W-1];
      for (int i = 1; i < W; i++) n[i] = s[i-1] ^ (MASK[i-1] & s[W-1]);
      return n;
   endfunction

   task automatic check(input string req, input string what, input logic [W-1:0] got, input logic [W-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   // one clock: drive at negedge, update models at posedge, compare after
   task automatic cyc(input logic r, input logic e, input logic l, input logic [W-1:0] v, input string req);
      @(negedge clk);
      rst = r; en = e; load = l; load_val = v;
      @(posedge clk);
      if (r) begin
         mf = 16'h0000; mg = 16'h0001;
      end else if (l) begin
         mf = (v == 16'hFFFF) ? 16'h0000 : v;
         mg = (v == 16'h0000) ? 16'h0001 : v;
      end else if (e) begin
         mf = fib_step(mf); mg = gal_step(mg);
      end
      #1;
      check(req, "xnor state", st_f, mf);
      check(req, "xor state", st_g, mg);
      check("R7", "xnor flag", {15'd0, lk_f}, {15'd0, mf == 16'hFFFF});
      check("R7", "xor flag", {15'd0, lk_g}, {15'd0, mg == 16'h0000});
   endtask

   task automatic period_run(input bit gal, output bit ok_rep, output bit ok_lock, output bit ok_ret);
      bit seen [logic [W-1:0]];
      logic [W-1:0] start, s;
      cyc(1'b1, 1'b0, 1'b0, '0, "R3");
      start = gal ? st_g : st_f;
      seen[start] = 1'b1;
      ok_rep = 1'b1; ok_lock = 1'b1; ok_ret = 1'b0;
      @(negedge clk);
      rst = 1'b0; en = 1'b1; load = 1'b0;
      for (int k = 1; k <= 65535; k++) begin
         @(posedge clk);
         #1;
         s = gal ? st_g : st_f;
         if ((gal ? lk_g : lk_f) || s == (gal ? 16'h0000 : 16'hFFFF)) ok_lock = 1'b0;
         if (k < 65535) begin
            if (seen.exists(s)) ok_rep = 1'b0;
            seen[s] = 1'b1;
         end else begin
            ok_ret = (s == start);
         end
      end
      @(negedge clk);
      en = 1'b0;
   endtask

   initial begin
      #(20ns * 200000);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit r_rep, r_lock, r_ret;
      void'($urandom(32'h5EED_1234));
      mf = '0; mg = '0;
      // R3 reset values
      cyc(1'b1, 1'b0, 1'b0, '0, "R3");
      cyc(1'b1, 1'b1, 1'b0, '0, "R3");
      // R4 hold
      for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0, 16'hA5A5, "R4");
      // R1 / R2 first steps from seeds
      for (int i = 0; i < 20; i++) cyc(1'b0, 1'b1, 1'b0, '0, "R1/R2");
      // R5 load wins over enable
      cyc(1'b0, 1'b1, 1'b1, 16'h1234, "R5");
      cyc(1'b0, 1'b1, 1'b0, '0, "R1/R2");
      // R6 lockup loads
      cyc(1'b0, 1'b1, 1'b1, 16'hFFFF, "R6");
      cyc(1'b0, 1'b0, 1'b1, 16'h0000, "R6");
      cyc(1'b0, 1'b1, 1'b0, '0, "R1/R2");
      cyc(1'b0, 1'b0, 1'b1, 16'h8000, "R5");
      cyc(1'b0, 1'b1, 1'b0, '0, "R2");
      // R5 reset beats load
      cyc(1'b1, 1'b1, 1'b1, 16'h5555, "R5");
      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic r, e, l;
         logic [W-1:0] v;
         int pick;
         r = ($urandom_range(63) == 0);
         e = $urandom_range(1);
         l = ($urandom_range(15) == 0);
         pick = $urandom_range(3);
         v = (pick == 0) ? 16'hFFFF : (pick == 1) ? 16'h0000 : W'($urandom);
         cyc(r, e, l, v, "R1/R2/R4/R5/R6");
      end
      // R8 full period, each form
      period_run(1'b0, r_rep, r_lock, r_ret);
      check("R8", "xnor no early repeat", {15'd0, r_rep}, 16'd1);
      check("R7", "xnor no lockup in period", {15'd0, r_lock}, 16'd1);
      check("R8", "xnor returns at 65535", {15'd0, r_ret}, 16'd1);
      period_run(1'b1, r_rep, r_lock, r_ret);
      check("R8", "xor no early repeat", {15'd0, r_rep}, 16'd1);
      check("R7", "xor no lockup in period", {15'd0, r_lock}, 16'd1);
      check("R8", "xor returns at 65535", {15'd0, r_ret}, 16'd1);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule